// File: doc/BRIEF.md
# DMA Error Capture Register Block

This block is the register front end that records bus faults seen by a 64-bit memory-side manager port shared by two internal DMA users: one moving payload data and one fetching command descriptors. Each fault arrives as a single-cycle event carrying a source tag and the 64-bit address that drew the error response. The block keeps one sticky status bit per source and raises an interrupt line whenever an enabled status bit is set. The first faulting address is held in a pair of 32-bit registers.

The held address stays frozen while any status bit is pending. Software therefore always sees the address of the first fault in a burst of faults. Once software has cleared both bits, the next fault is captured again.

Software reaches the block through a 32-bit APB completer. A general configuration register only accepts writes while the controller reports idle. The status, interrupt-enable and fault-address registers stay fully usable at all times.

Top module: `dmaerr_regblk`

## Requirements
- R1: After synchronous reset, every register reads zero, `irq` is low and `cfg_value` is zero.
- R2: A fault event (`err_valid` high) with `err_src` = 0 (data DMA) sets status bit 0 at offset 0x110. With `err_src` = 1 (descriptor DMA) it sets status bit 1. The bit is visible from the next cycle.
- R3: Status bits are write-one-to-clear. An APB write to 0x110 clears each bit whose `pwdata` bit is 1. Bits written with 0 keep their value.
- R4: On capture, offset 0x140 holds fault address bits 31:0. Offset 0x144 holds bits 39:32 in its bits 7:0 and zero in bits 31:8. Address bits 63:40 are dropped.
- R5: While any status bit is set, a new fault sets its status bit but leaves the captured address unchanged.
- R6: If a fault arrives in the same cycle that a status write clears the last pending bit, the new bit is set and its address is captured.
- R7: The interrupt-enable register at 0x114 holds one enable per source in bits 1:0. `irq` is high exactly when some status bit and its enable are both 1.
- R8: The configuration register at 0x000 (read back there and on `cfg_value`) is written only when `ctrl_idle` is high. Writes while busy are dropped.
- R9: Writes to 0x110 and 0x114 take effect regardless of `ctrl_idle`.
- R10: `pready` is always high. `pslverr` is high in the access phase of a transfer to any offset other than 0x000, 0x110, 0x114, 0x140 and 0x144, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error for unmapped offsets |
| ctrl_idle | input | 1 | Controller idle indication, gates configuration writes |
| err_valid | input | 1 | One-cycle fault event |
| err_src | input | 1 | Fault source: 0 data DMA, 1 descriptor DMA |
| err_addr | input | 64 | Address that drew the error response |
| cfg_value | output | 32 | Current configuration register value |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a fault sets its source's status bit;
- a write-one-to-clear write without a colliding fault clears the bit;
- the captured address cannot move while a bit is pending and no status write is in progress;
- a configuration write while busy leaves the register alone;
- the interrupt never rises without a pending bit;
- the error response only appears in an access phase.

Some behaviours need the bench's scenarios. These are the exact captured values with the unused upper address bits masked off, and the same-cycle clear-and-fault collision where the address is recaptured. Others are the enable masking of a pending bit, writes to status and enable while busy, and the full decode of mapped and unmapped offsets.

// File: rtl/dmaerr_pkg.sv
package dmaerr_pkg;

    localparam int DEC_AW = 16;

    localparam logic [DEC_AW-1:0] OFS_CFG  = 16'h0000;
    localparam logic [DEC_AW-1:0] OFS_STS  = 16'h0110;
    localparam logic [DEC_AW-1:0] OFS_IEN  = 16'h0114;
    localparam logic [DEC_AW-1:0] OFS_ALO  = 16'h0140;
    localparam logic [DEC_AW-1:0] OFS_AHI  = 16'h0144;

    typedef struct packed {
        logic cfg;
        logic sts;
        logic ien;
        logic alo;
        logic ahi;
    } regsel_t;

    function automatic regsel_t decode_ofs(input logic [DEC_AW-1:0] a);
        regsel_t s;
        s.cfg = (a == OFS_CFG);
        s.sts = (a == OFS_STS);
        s.ien = (a == OFS_IEN);
        s.alo = (a == OFS_ALO);
        s.ahi = (a == OFS_AHI);
        return s;
    endfunction

    function automatic logic any_sel(input regsel_t s);
        return s.cfg | s.sts | s.ien | s.alo | s.ahi;
    endfunction

endpackage

// File: rtl/dmaerr_apb_dec.sv
module dmaerr_apb_dec
    import dmaerr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    output regsel_t       sel,
    output logic          wr_en,
    output logic          slverr
);
    logic access;

    assign access = psel & penable;
    assign sel    = decode_ofs(DEC_AW'(paddr));
    assign wr_en  = access & pwrite;
    assign slverr = access & ~any_sel(sel);
endmodule

// File: rtl/dmaerr_wreg.sv
module dmaerr_wreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/dmaerr_sts_cap.sv
module dmaerr_sts_cap #(
    parameter int NSRC    = 2,
    parameter int SRCW    = 1,
    parameter int MAW     = 64,
    parameter int USED_AW = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    clr_mask,
    input  logic               ev_valid,
    input  logic [SRCW-1:0]    ev_src,
    input  logic [MAW-1:0]     ev_addr,
    output logic [NSRC-1:0]    sts,
    output logic [USED_AW-1:0] cap_addr
);
    logic [NSRC-1:0] after_clr;
    logic [NSRC-1:0] set_vec;
    logic            cap_en;
    logic            unused_addr_hi;

    assign after_clr      = sts & ~clr_mask;
    assign set_vec        = ev_valid ? (NSRC'(1) << ev_src) : '0;
    assign cap_en         = ev_valid && (after_clr == '0);
    assign unused_addr_hi = ^ev_addr[MAW-1:USED_AW];

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                sts[i] <= 1'b0;
            end else begin
                sts[i] <= after_clr[i] | set_vec[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_addr <= '0;
        end else if (cap_en) begin
            cap_addr <= ev_addr[USED_AW-1:0];
        end
    end
endmodule

// File: rtl/dmaerr_regblk.sv
module dmaerr_regblk
    import dmaerr_pkg::*;
#(
    parameter int AW      = 12,
    parameter int DW      = 32,
    parameter int MAW     = 64,
    parameter int USED_AW = 40,
    parameter int NSRC    = 2,
    parameter int SRCW    = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            psel,
    input  logic            penable,
    input  logic            pwrite,
    input  logic [AW-1:0]   paddr,
    input  logic [DW-1:0]   pwdata,
    output logic [DW-1:0]   prdata,
    output logic            pready,
    output logic            pslverr,
    input  logic            ctrl_idle,
    input  logic            err_valid,
    input  logic [SRCW-1:0] err_src,
    input  logic [MAW-1:0]  err_addr,
    output logic [DW-1:0]   cfg_value,
    output logic            irq
);
    localparam int HI_W = USED_AW - DW;

    regsel_t            sel;
    logic               wr_en;
    logic [NSRC-1:0]    clr_mask;
    logic [NSRC-1:0]    sts_q;
    logic [NSRC-1:0]    ien_q;
    logic [USED_AW-1:0] cap_addr_q;
    logic [DW-1:0]      cfg_q;

    dmaerr_apb_dec #(.AW(AW)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .sel     (sel),
        .wr_en   (wr_en),
        .slverr  (pslverr)
    );

    dmaerr_wreg #(.W(DW)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en & sel.cfg & ctrl_idle),
        .wdata (pwdata),
        .q     (cfg_q)
    );

    dmaerr_wreg #(.W(NSRC)) u_ien (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en & sel.ien),
        .wdata (pwdata[NSRC-1:0]),
        .q     (ien_q)
    );

    assign clr_mask = (wr_en & sel.sts) ? pwdata[NSRC-1:0] : '0;

    dmaerr_sts_cap #(
        .NSRC    (NSRC),
        .SRCW    (SRCW),
        .MAW     (MAW),
        .USED_AW (USED_AW)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .clr_mask (clr_mask),
        .ev_valid (err_valid),
        .ev_src   (err_src),
        .ev_addr  (err_addr),
        .sts      (sts_q),
        .cap_addr (cap_addr_q)
    );

    always_comb begin
        prdata = '0;
        if (sel.cfg) begin
            prdata = cfg_q;
        end else if (sel.sts) begin
            prdata[NSRC-1:0] = sts_q;
        end else if (sel.ien) begin
            prdata[NSRC-1:0] = ien_q;
        end else if (sel.alo) begin
            prdata = cap_addr_q[DW-1:0];
        end else if (sel.ahi) begin
            prdata[HI_W-1:0] = cap_addr_q[USED_AW-1:DW];
        end
    end

    assign pready    = 1'b1;
    assign cfg_value = cfg_q;
    assign irq       = |(sts_q & ien_q);
endmodule

// File: rtl/dmaerr_regblk_chk.sv
module dmaerr_regblk_chk #(
    parameter int AW      = 12,
    parameter int DW      = 32,
    parameter int USED_AW = 40,
    parameter int NSRC    = 2,
    parameter int SRCW    = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [AW-1:0]      paddr,
    input logic [NSRC-1:0]    wlo,
    input logic               pslverr,
    input logic               ctrl_idle,
    input logic               err_valid,
    input logic [SRCW-1:0]    err_src,
    input logic               irq,
    input logic [NSRC-1:0]    sts,
    input logic [USED_AW-1:0] cap_addr,
    input logic [DW-1:0]      cfg
);
    logic sts_wr;
    assign sts_wr = psel && penable && pwrite && (paddr == AW'(12'h110));

    a_r2_data_sets: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_src == SRCW'(0)) |=> sts[0]);

    a_r2_cmd_sets: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_src == SRCW'(1)) |=> sts[1]);

    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && wlo[0] && !(err_valid && err_src == SRCW'(0))) |=> !sts[0]);

    a_r5_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        ((|sts) && !sts_wr) |=> $stable(cap_addr));

    a_r8_cfg_gated: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite && !ctrl_idle) |=> $stable(cfg));

    a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|sts));

    a_r10_slverr_access: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> (psel && penable));
endmodule

bind dmaerr_regblk dmaerr_regblk_chk #(
    .AW      (AW),
    .DW      (DW),
    .USED_AW (USED_AW),
    .NSRC    (NSRC),
    .SRCW    (SRCW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .wlo       (pwdata[NSRC-1:0]),
    .pslverr   (pslverr),
    .ctrl_idle (ctrl_idle),
    .err_valid (err_valid),
    .err_src   (err_src),
    .irq       (irq),
    .sts       (sts_q),
    .cap_addr  (cap_addr_q),
    .cfg       (cfg_q)
);

// File: tb/dmaerr_regblk_tb.sv
`timescale 1ns/1ps
module dmaerr_regblk_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        ctrl_idle = 1'b1;
    logic        err_valid = 1'b0;
    logic [0:0]  err_src = '0;
    logic [63:0] err_addr = '0;
    logic [31:0] cfg_value;
    logic        irq;

    int vectors = 0;
    int misses  = 0;

    logic [31:0] last_rdata;
    logic        last_slverr, last_ready;

    // reference model state
    logic [1:0]  m_sts = '0, m_ien = '0;
    logic [31:0] m_cfg = '0, m_alo = '0, m_ahi = '0;

    always #4 clk = ~clk;

    dmaerr_regblk u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .ctrl_idle(ctrl_idle), .err_valid(err_valid),
        .err_src(err_src), .err_addr(err_addr), .cfg_value(cfg_value), .irq(irq)
    );

    always @(posedge clk) begin
        logic       wr;
        logic [1:0] left;
        if (rst) begin
            m_sts = '0; m_ien = '0; m_cfg = '0; m_alo = '0; m_ahi = '0;
        end else begin
            wr   = psel && penable && pwrite;
            left = m_sts;
            if (wr && paddr == 12'h110) left = left & ~pwdata[1:0];
            if (err_valid) begin
                if (left == 2'b00) begin
                    m_alo = err_addr[31:0];
                    m_ahi = {24'h0, err_addr[39:32]};
                end
                left = left | (err_src == 1'b0 ? 2'b01 : 2'b10);
            end
            m_sts = left;
            if (wr && paddr == 12'h114) m_ien = pwdata[1:0];
            if (wr && paddr == 12'h000 && ctrl_idle) m_cfg = pwdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every clock against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 irq", {31'h0, irq}, {31'h0, |(m_sts & m_ien)});
            chk("R8 cfg_value", cfg_value, m_cfg);
        end
    end

    task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic inj, input logic s, input logic [63:0] ea);
        @(negedge clk);
        psel = 1'b1; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        if (inj) begin
            err_valid = 1'b1; err_src = s; err_addr = ea;
        end
        #1;
        last_rdata = prdata; last_slverr = pslverr; last_ready = pready;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; err_valid = 1'b0;
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        xfer(1'b1, a, d, 1'b0, 1'b0, 64'h0);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        xfer(1'b0, a, 32'h0, 1'b0, 1'b0, 64'h0);
        chk(req, last_rdata, exp);
    endtask

    task automatic inject(input logic s, input logic [63:0] ea);
        @(negedge clk);
        err_valid = 1'b1; err_src = s; err_addr = ea;
        @(negedge clk);
        err_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 cfg_value", cfg_value, 32'h0);
        rd_chk("R1 sts", 12'h110, 32'h0);
        rd_chk("R1 ien", 12'h114, 32'h0);
        rd_chk("R1 alo", 12'h140, 32'h0);
        rd_chk("R1 ahi", 12'h144, 32'h0);
        rd_chk("R1 cfg", 12'h000, 32'h0);
        chk("R10 mapped no slverr", {31'h0, last_slverr}, 32'h0);
        chk("R10 pready", {31'h0, last_ready}, 32'h1);

        // R10 unmapped offsets
        xfer(1'b0, 12'h100, 32'h0, 1'b0, 1'b0, 64'h0);
        chk("R10 unmapped read slverr", {31'h0, last_slverr}, 32'h1);
        xfer(1'b1, 12'h142, 32'h1, 1'b0, 1'b0, 64'h0);
        chk("R10 unmapped write slverr", {31'h0, last_slverr}, 32'h1);
        chk("R10 pready", {31'h0, last_ready}, 32'h1);

        // R7 enable
        wr_reg(12'h114, 32'h3);
        rd_chk("R7 ien readback", 12'h114, 32'h3);

        // R2, R4 data fault
        inject(1'b0, 64'hABCD_EF12_3456_789A);
        rd_chk("R2 data bit", 12'h110, 32'h1);
        rd_chk("R4 alo", 12'h140, 32'h3456_789A);
        rd_chk("R4 ahi masked", 12'h144, 32'h0000_0012);
        chk("R7 irq set", {31'h0, irq}, 32'h1);

        // R5 frozen address
        inject(1'b1, 64'h0000_0055_1111_2222);
        rd_chk("R2 cmd bit", 12'h110, 32'h3);
        rd_chk("R5 alo frozen", 12'h140, 32'h3456_789A);
        rd_chk("R5 ahi frozen", 12'h144, 32'h0000_0012);

        // R3 W1C
        wr_reg(12'h110, 32'h1);
        rd_chk("R3 clear bit0", 12'h110, 32'h2);
        rd_chk("R5 alo still frozen", 12'h140, 32'h3456_789A);
        wr_reg(12'h110, 32'h0);
        rd_chk("R3 zero write keeps", 12'h110, 32'h2);

        // R7 masking
        wr_reg(12'h114, 32'h1);
        chk("R7 irq masked", {31'h0, irq}, 32'h0);
        wr_reg(12'h114, 32'h3);
        chk("R7 irq unmasked", {31'h0, irq}, 32'h1);

        // R6 clear and fault in same cycle
        xfer(1'b1, 12'h110, 32'h2, 1'b1, 1'b0, 64'hFFFF_FF77_0000_0040);
        rd_chk("R6 set wins", 12'h110, 32'h1);
        rd_chk("R6 alo recaptured", 12'h140, 32'h0000_0040);
        rd_chk("R6 ahi recaptured", 12'h144, 32'h0000_0077);

        // R4 fresh capture after full clear
        wr_reg(12'h110, 32'h3);
        rd_chk("R3 all clear", 12'h110, 32'h0);
        rd_chk("R4 alo kept after clear", 12'h140, 32'h0000_0040);
        inject(1'b1, 64'h0000_0001_2345_6789);
        rd_chk("R2 cmd only", 12'h110, 32'h2);
        rd_chk("R4 alo new", 12'h140, 32'h2345_6789);
        rd_chk("R4 ahi new", 12'h144, 32'h0000_0001);

        // R8, R9 busy controller
        ctrl_idle = 1'b0;
        wr_reg(12'h000, 32'hDEAD_BEEF);
        rd_chk("R8 cfg dropped busy", 12'h000, 32'h0);
        chk("R8 cfg_value busy", cfg_value, 32'h0);
        wr_reg(12'h114, 32'h1);
        rd_chk("R9 ien busy write", 12'h114, 32'h1);
        chk("R7 irq masked cmd", {31'h0, irq}, 32'h0);
        wr_reg(12'h110, 32'h2);
        rd_chk("R9 sts busy clear", 12'h110, 32'h0);
        ctrl_idle = 1'b1;
        wr_reg(12'h000, 32'hDEAD_BEEF);
        rd_chk("R8 cfg idle write", 12'h000, 32'hDEAD_BEEF);
        chk("R8 cfg_value idle", cfg_value, 32'hDEAD_BEEF);

        // register model compared during idle cycles too
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule